// File: doc/BRIEF.md
# Deglitched UART Start-Bit Wake Detector

This block is the receive front end of a UART in a system that sleeps between characters. The serial line is brought into the clock domain by a two-flop synchronizer. The line is then examined only on a 16x oversampling tick. A falling edge does not wake anything by itself. The line must stay low for a programmable number of ticks before a sticky wake flag is raised. That flag is raised before the start bit itself has been judged.

At mid-bit, three samples of the start bit are put to a majority vote. A valid start bit leads into normal reception of eight data bits, least significant first, each judged by the same vote. When the vote rejects the start bit, the character is dropped silently. In that case there is no receive-done pulse and the data register keeps its value. After any character or abort, the line must be seen high again before a new start can be detected, so a line stuck low cannot retrigger.

The wake flag doubles as the start interrupt request while the start-interrupt enable is set. Software clears the enable to drop the request and reset the flag. From then on the receive-done pulse is the block's interrupt source.

Top module: `uart_wake_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `wake_flag` and `rx_done` are 0 and `rx_data` is 0x00.
- R2: The line is idle high and a start bit is low. Call L the effective deglitch length, which is `glitch_len`. A low level seen on at most L consecutive ticks (tick indices 0..L-1, index 0 being the first tick that sees it low) sets no wake flag, produces no `rx_done` and leaves `rx_data` unchanged.
- R3: If the line is low on tick indices 0..L, then `wake_flag` rises in the clock cycle after tick L, provided `start_ie` is 1. This happens whether or not the start bit later passes the vote.
- R4: The start bit is voted on tick indices 7, 8 and 9, and it is valid when at least two of those samples are low. A rejected start bit produces no `rx_done`, and `rx_data` keeps its previous value.
- R5: After a valid start bit, each of 8 data bits occupies 16 ticks and is taken LSB first by the same 2-of-3 vote on its ticks 7, 8 and 9. On tick 10 of the following stop bit, `rx_data` is loaded, and `rx_done` is 1 for exactly one clock in the cycle after that tick.
- R6: `wake_flag` stays 1 for as long as `start_ie` stays 1. In the cycle after `start_ie` is seen at 0, the flag is 0. It cannot be set while `start_ie` is 0, and raising `start_ie` again does not restore it.
- R7: After a character, or after a rejected start, start detection is re-armed only after a tick that sees the line high. A line held low therefore yields at most one character and one wake event.
- R8: `glitch_len` takes values 1 to 15. A value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw serial input, idle high |
| os_tick | input | 1 | One-clock pulse at 16x the bit rate |
| glitch_len | input | 4 | Deglitch length in ticks (1..15, 0 acts as 1) |
| start_ie | input | 1 | Start-interrupt enable; 0 clears and blocks the wake flag |
| wake_flag | output | 1 | Sticky start-detect wake flag and start interrupt request |
| rx_done | output | 1 | One-clock receive-complete pulse |
| rx_data | output | 8 | Last received character |

## Verification
Every result of this block trails the tick that decides it by one clock. The wake flag follows tick L of the start bit, and the done pulse and new data follow tick 10 of the stop bit. The synchronizer adds two clocks on the input side, so the bench changes the line three clocks before each tick it issues, and every tick sees the level meant for it. The wake flag and the data are read only after extra idle ticks, once the result is due. Done pulses are counted at falling clock edges, so a missing, extra or widened pulse shows up in the count.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wk_vote3.sv
module wk_vote3 #(
  parameter int PH_W = 4,
  parameter int MID  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] idx,
  input  logic            din,
  output logic            vote_low
);
  localparam logic [PH_W-1:0] S_LO  = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] S_MID = PH_W'(MID);
  localparam logic [PH_W-1:0] S_HI  = PH_W'(MID + 1);

  logic [1:0] cnt_q, cnt_d;
  logic       in_window;

  always_comb begin
    in_window = (idx == S_LO) || (idx == S_MID) || (idx == S_HI);
    cnt_d     = cnt_q;
    if (tick) begin
      if (idx == '0)                cnt_d = 2'd0;
      else if (in_window && !din)   cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  assign vote_low = (cnt_q >= 2'd2);
endmodule

// File: rtl/wk_wake.sv
module wk_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = enable & (flag_q | set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/wk_rx_fsm.sv
module wk_rx_fsm
  import uart_wake_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8,
  parameter int GLEN_W    = 4,
  localparam int PH_W     = $clog2(OSR),
  localparam int BC_W     = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx,
  input  logic [GLEN_W-1:0]    glen,
  input  logic                 vote_low,
  output logic [PH_W-1:0]      idx,
  output logic                 wake_set,
  output logic                 done,
  output logic [DATA_BITS-1:0] data
);
  localparam int CW = (PH_W > GLEN_W) ? PH_W : GLEN_W;
  localparam logic [PH_W-1:0] LAST     = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] STOP_IDX = PH_W'(OSR / 2 + 2);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_BITS - 1);

  rx_state_e             state_q, state_d;
  logic [PH_W-1:0]       phase_q, phase_d;
  logic                  dg_q, dg_d;
  logic [BC_W-1:0]       bit_q, bit_d;
  logic [DATA_BITS-1:0]  sh_q, sh_d;
  logic [DATA_BITS-1:0]  data_q, data_d;
  logic                  done_q, done_d;
  logic [GLEN_W-1:0]     glen_eff;
  logic [CW-1:0]         idx_w, len_w;
  logic                  abort_dg, pass_dg;

  always_comb begin
    glen_eff = (glen == '0) ? GLEN_W'(1) : glen;
    idx      = (state_q == ST_IDLE) ? '0 : phase_q + 1'b1;
    idx_w    = CW'(idx);
    len_w    = CW'(glen_eff);
    abort_dg = !dg_q && rx;
    pass_dg  = !dg_q && !rx && (idx_w == len_w);
  end

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    dg_d     = dg_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    data_d   = data_q;
    done_d   = 1'b0;
    wake_set = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx) begin
            state_d = ST_START;
            phase_d = '0;
            dg_d    = 1'b0;
          end
        end
        ST_START: begin
          phase_d = idx;
          if (abort_dg) begin
            state_d = ST_IDLE;
          end else begin
            if (pass_dg) begin
              dg_d     = 1'b1;
              wake_set = 1'b1;
            end
            if (idx == LAST) begin
              bit_d   = '0;
              state_d = ((dg_q || pass_dg) && vote_low) ? ST_DATA : ST_HOLD;
            end
          end
        end
        ST_DATA: begin
          phase_d = idx;
          if (idx == LAST) begin
            sh_d  = {!vote_low, sh_q[DATA_BITS-1:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == LAST_BIT) state_d = ST_STOP;
          end
        end
        ST_STOP: begin
          phase_d = idx;
          if (idx == STOP_IDX) begin
            data_d  = sh_q;
            done_d  = 1'b1;
            state_d = vote_low ? ST_HOLD : ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (rx) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      dg_q    <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      dg_q    <= dg_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int GLEN_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_in,
  input  logic                 os_tick,
  input  logic [GLEN_W-1:0]    glitch_len,
  input  logic                 start_ie,
  output logic                 wake_flag,
  output logic                 rx_done,
  output logic [DATA_BITS-1:0] rx_data
);
  localparam int PH_W = $clog2(OSR);

  logic            rx_s;
  logic [PH_W-1:0] tick_idx;
  logic            vote_low;
  logic            wake_set;

  wk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  wk_vote3 #(.PH_W(PH_W), .MID(OSR / 2)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .idx(tick_idx),
    .din(rx_s), .vote_low(vote_low)
  );

  wk_rx_fsm #(.OSR(OSR), .DATA_BITS(DATA_BITS), .GLEN_W(GLEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .glen(glitch_len),
    .vote_low(vote_low), .idx(tick_idx), .wake_set(wake_set),
    .done(rx_done), .data(rx_data)
  );

  wk_wake u_wake (
    .clk(clk), .rst_n(rst_n), .enable(start_ie), .set(wake_set), .flag(wake_flag)
  );
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 os_tick,
  input logic                 start_ie,
  input logic                 wake_flag,
  input logic                 rx_done,
  input logic [DATA_BITS-1:0] rx_data
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);                                   // R5
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(os_tick));                             // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_data));                          // R4
  AST_WAKE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(os_tick));                    // R3
  AST_WAKE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ie |=> !wake_flag);                               // R6
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && start_ie) |=> wake_flag);                  // R6
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .start_ie(start_ie),
  .wake_flag(wake_flag), .rx_done(rx_done), .rx_data(rx_data)
);

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
  logic       clk;
  logic       rst_n;
  logic       rx_in;
  logic       os_tick;
  logic [3:0] glitch_len;
  logic       start_ie;
  logic       wake_flag;
  logic       rx_done;
  logic [7:0] rx_data;

  int n_chk  = 0;
  int n_err  = 0;
  int n_done = 0;

  uart_wake_rx i_uart_wake_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .glitch_len(glitch_len), .start_ie(start_ie), .wake_flag(wake_flag),
    .rx_done(rx_done), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: mask[32:17] start-bit level per tick, byte[16:9], glen[8:5],
  // flip[4] (sample 8 of each data bit inverted), data[3], ie[2], exp wake[1], exp done[0]
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0000, 8'hA5, 4'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 R5
    {16'h0000, 8'h3C, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 R8 longest
    {16'h0000, 8'h00, 4'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 vote on data
    {16'h0000, 8'hFF, 4'd7,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 vote on data
    {16'hFFF8, 8'h00, 4'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 glitch = L
    {16'hFFF0, 8'h00, 4'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 R4 wake then reject
    {16'h0100, 8'h5A, 4'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 one high sample
    {16'h0300, 8'h00, 4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 two high samples
    {16'h8000, 8'h00, 4'd15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 15 ticks, L=15
    {16'h0000, 8'hC3, 4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 enable off
    {16'hFFFE, 8'h00, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 zero acts as 1
    {16'hFFFC, 8'h00, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R8 zero acts as 1
  };

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic one_tick();
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic level_ticks(input logic lvl, input int n);
    rx_in = lvl;
    repeat (n) one_tick();
  endtask

  task automatic send_frame(input logic [15:0] mask, input logic [7:0] b,
                            input bit flip, input bit with_data);
    for (int i = 0; i < 16; i++) begin
      rx_in = mask[i];
      one_tick();
    end
    if (with_data) begin
      for (int j = 0; j < 8; j++) begin
        for (int t = 0; t < 16; t++) begin
          rx_in = (flip && t == 8) ? ~b[j] : b[j];
          one_tick();
        end
      end
      level_ticks(1'b1, 36);
    end else begin
      level_ticks(1'b1, 40);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rx_done === 1'b1) n_done++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] prev;
    rst_n = 1'b0; rx_in = 1'b1; os_tick = 1'b0; glitch_len = 4'd3; start_ie = 1'b0;
    repeat (5) @(negedge clk);
    check(wake_flag === 1'b0 && rx_done === 1'b0, "R1 flags in reset", {wake_flag, rx_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wake_flag === 1'b0, "R1 wake after reset", wake_flag, 0);
    check(rx_done === 1'b0, "R1 done after reset", rx_done, 0);
    check(rx_data === 8'h00, "R1 data after reset", rx_data, 0);
    level_ticks(1'b1, 4);

    for (int v = 0; v < NV; v++) begin
      glitch_len = VEC[v][8:5];
      start_ie = 1'b0;
      repeat (2) @(negedge clk);
      start_ie = VEC[v][2];
      base = n_done;
      prev = rx_data;
      send_frame(VEC[v][32:17], VEC[v][16:9], VEC[v][4], VEC[v][3]);
      check(wake_flag === VEC[v][1], $sformatf("R2/R3/R6 wake, vector %0d", v),
            wake_flag, VEC[v][1]);
      check((n_done - base) == int'(VEC[v][0]), $sformatf("R4/R5 done count, vector %0d", v),
            n_done - base, VEC[v][0]);
      if (VEC[v][0])
        check(rx_data === VEC[v][16:9], $sformatf("R5 data, vector %0d", v),
              rx_data, VEC[v][16:9]);
      else
        check(rx_data === prev, $sformatf("R4 data kept, vector %0d", v), rx_data, prev);
    end

    // R6: sticky while enabled, cleared by enable low, not restored
    level_ticks(1'b1, 30);
    check(wake_flag === 1'b1, "R6 wake sticky", wake_flag, 1);
    start_ie = 1'b0;
    repeat (2) @(negedge clk);
    check(wake_flag === 1'b0, "R6 wake cleared", wake_flag, 0);
    start_ie = 1'b1;
    level_ticks(1'b1, 10);
    check(wake_flag === 1'b0, "R6 wake not restored", wake_flag, 0);

    // R7: line stuck low
    glitch_len = 4'd3;
    base = n_done;
    level_ticks(1'b0, 200);
    check((n_done - base) == 1, "R7 one char on stuck line", n_done - base, 1);
    check(rx_data === 8'h00, "R7 data on stuck line", rx_data, 0);
    check(wake_flag === 1'b1, "R7 wake on stuck line", wake_flag, 1);
    start_ie = 1'b0;
    repeat (2) @(negedge clk);
    start_ie = 1'b1;
    level_ticks(1'b0, 60);
    check(wake_flag === 1'b0, "R7 no re-arm while low", wake_flag, 0);
    check((n_done - base) == 1, "R7 no extra char", n_done - base, 1);
    level_ticks(1'b1, 5);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule